// File: doc/BRIEF.md
# Single-Cycle Integer Processor Core

This block is a 32-bit processor core that completes one instruction in every clock cycle. It executes a seven-instruction integer subset: register add and subtract, OR with an unsigned immediate, word load, word store, branch on equal, and an absolute jump. The core holds its program counter, a 32 x 32 register file, an immediate extender, an ALU, a decoder and the next-PC logic. It also holds two small word-addressed memories, one for instructions and one for data.

Memory contents are written through a load port. This is normally done while reset is held, so that a program and its initial data are in place before the first instruction executes. Every write the core makes is visible at its ports in the cycle that makes it. The register write-back port gives the destination, the data and the enable. The data-memory store port gives the address, the data and the enable. The program counter is also brought out, so the instruction flow can be followed cycle by cycle.

Top module: `sc_core`

## Requirements
- R1: While reset is high at a rising clock edge, the program counter becomes 0. While reset is high, wbEn and memWe are 0.
- R2: An instruction with opcode 000000 and funct 100000 writes R[rs]+R[rt] to register rd. With funct 100010 it writes R[rs]-R[rt] to rd. The fields are op[31:26], rs[25:21], rt[20:16], rd[15:11] and funct[5:0].
- R3: Opcode 001101 writes R[rs] OR the zero-extended imm[15:0] to register rt.
- R4: Opcode 100011 (load) writes the data word at R[rs]+sign-extended imm to rt. Opcode 101011 (store) writes R[rt] to that address. The data word index is address bits [7:2].
- R5: Only add, sub, the OR-immediate and load assert wbEn. Only store asserts memWe.
- R6: Opcode 000100 compares R[rs] with R[rt]. If they are equal, the next PC is PC+4 plus the sign-extended immediate shifted left by 2. Otherwise the next PC is PC+4.
- R7: Opcode 000010 sets the next PC to {PC+4 bits[31:28], target[25:0], 2'b00}.
- R8: Register 0 always reads as 0. A write to register 0 still shows on the write-back port but changes nothing.
- R9: An unknown opcode, or an unknown funct with opcode 000000, writes nothing and advances the PC by 4.
- R10: Every instruction other than a branch or a jump sets the next PC to PC+4.
- R11: A load-port write with loadToData=0 stores loadData into instruction word loadAddr. That word is fetched when PC = 4*loadAddr. With loadToData=1, the word goes to data word loadAddr instead.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous reset, active high |
| loadEn | input | 1 | Write one memory word from the load port |
| loadToData | input | 1 | Load target: 0 selects instruction memory, 1 selects data memory |
| loadAddr | input | 6 | Word index for the load write |
| loadData | input | 32 | Word written by the load port |
| pcOut | output | 32 | Current program counter |
| wbEn | output | 1 | A register write happens at the next edge |
| wbReg | output | 5 | Destination register of that write |
| wbData | output | 32 | Data of that write |
| memWe | output | 1 | A data-memory store happens at the next edge |
| memAddr | output | 32 | Byte address computed by the ALU |
| memWdata | output | 32 | Store data, R[rt] |

## Verification
The assertions assume three things. Reset is held high from time zero. The load port is idle while the core runs. The instruction memory holds a defined word at every PC the program reaches. The stimulus loads the whole program and its data while reset is high, with every fetched word written and unreached slots filled with a marker. Reset is then released on a falling edge, and the load port stays idle from that point on. The program ends in a branch back to itself, so the PC never leaves the loaded range.

// File: rtl/sc_pkg.sv
package sc_pkg;
  localparam logic [5:0] OP_RTYPE = 6'b000000;
  localparam logic [5:0] OP_ORI   = 6'b001101;
  localparam logic [5:0] OP_LW    = 6'b100011;
  localparam logic [5:0] OP_SW    = 6'b101011;
  localparam logic [5:0] OP_BEQ   = 6'b000100;
  localparam logic [5:0] OP_J     = 6'b000010;
  localparam logic [5:0] FN_ADD   = 6'b100000;
  localparam logic [5:0] FN_SUB   = 6'b100010;

  typedef enum logic [1:0] {ALU_ADD, ALU_SUB, ALU_OR} aluOp_e;

  typedef struct packed {
    logic   regDst;
    logic   aluSrcImm;
    logic   extSign;
    logic   memToReg;
    logic   regWrite;
    logic   memWrite;
    logic   branch;
    logic   jump;
    aluOp_e aluOp;
  } ctrl_t;
endpackage

// File: rtl/sc_control.sv
module sc_control
  import sc_pkg::*;
(
  input  logic [5:0] opcode,
  input  logic [5:0] funct,
  output ctrl_t      ctrl
);
  always_comb begin
    ctrl = '0;
    ctrl.aluOp = ALU_ADD;
    case (opcode)
      OP_RTYPE: begin
        if (funct == FN_ADD) begin
          ctrl.regWrite = 1'b1;
          ctrl.regDst   = 1'b1;
          ctrl.aluOp    = ALU_ADD;
        end else if (funct == FN_SUB) begin
          ctrl.regWrite = 1'b1;
          ctrl.regDst   = 1'b1;
          ctrl.aluOp    = ALU_SUB;
        end
      end
      OP_ORI: begin
        ctrl.aluSrcImm = 1'b1;
        ctrl.regWrite  = 1'b1;
        ctrl.aluOp     = ALU_OR;
      end
      OP_LW: begin
        ctrl.aluSrcImm = 1'b1;
        ctrl.extSign   = 1'b1;
        ctrl.memToReg  = 1'b1;
        ctrl.regWrite  = 1'b1;
      end
      OP_SW: begin
        ctrl.aluSrcImm = 1'b1;
        ctrl.extSign   = 1'b1;
        ctrl.memWrite  = 1'b1;
      end
      OP_BEQ: begin
        ctrl.branch  = 1'b1;
        ctrl.extSign = 1'b1;
        ctrl.aluOp   = ALU_SUB;
      end
      OP_J: ctrl.jump = 1'b1;
      default: ;
    endcase
  end
endmodule

// File: rtl/sc_regfile.sv
module sc_regfile #(
  parameter int W      = 32,
  parameter int REG_AW = 5
) (
  input  logic              clk,
  input  logic              we,
  input  logic [REG_AW-1:0] wAddr,
  input  logic [W-1:0]      wData,
  input  logic [REG_AW-1:0] rAddrA,
  input  logic [REG_AW-1:0] rAddrB,
  output logic [W-1:0]      rDataA,
  output logic [W-1:0]      rDataB
);
  localparam int NREGS = 1 << REG_AW;

  logic [W-1:0] regs [NREGS];
  logic [REG_AW-1:0] rAddr [2];
  logic [W-1:0]      rData [2];

  assign rAddr[0] = rAddrA;
  assign rAddr[1] = rAddrB;

  always_ff @(posedge clk) begin
    if (we && (wAddr != '0)) regs[wAddr] <= wData;
  end

  for (genvar p = 0; p < 2; p++) begin : gRead
    assign rData[p] = (rAddr[p] == '0) ? '0 : regs[rAddr[p]];
  end

  assign rDataA = rData[0];
  assign rDataB = rData[1];
endmodule

// File: rtl/sc_mem.sv
module sc_mem #(
  parameter int W  = 32,
  parameter int AW = 6
) (
  input  logic          clk,
  input  logic          we,
  input  logic [AW-1:0] wAddr,
  input  logic [W-1:0]  wData,
  input  logic [AW-1:0] rAddr,
  output logic [W-1:0]  rData
);
  localparam int DEPTH = 1 << AW;

  logic [W-1:0] words [DEPTH];

  always_ff @(posedge clk) begin
    if (we) words[wAddr] <= wData;
  end

  assign rData = words[rAddr];
endmodule

// File: rtl/sc_datapath.sv
module sc_datapath
  import sc_pkg::*;
#(
  parameter int W      = 32,
  parameter int REG_AW = 5,
  parameter int MEM_AW = 6
) (
  input  logic              clk,
  input  logic              rst,
  input  ctrl_t             ctrl,
  output logic [W-1:0]      instr,
  input  logic              loadEn,
  input  logic              loadToData,
  input  logic [MEM_AW-1:0] loadAddr,
  input  logic [W-1:0]      loadData,
  output logic [W-1:0]      pcOut,
  output logic              wbEn,
  output logic [REG_AW-1:0] wbReg,
  output logic [W-1:0]      wbData,
  output logic              memWe,
  output logic [W-1:0]      memAddr,
  output logic [W-1:0]      memWdata
);
  localparam int IMM_W  = 16;
  localparam int TGT_W  = 26;
  localparam int HIGH_W = W - TGT_W - 2;

  logic [W-1:0] pc, pcPlus4, nextPc, brTgt, jTgt;
  logic [W-1:0] immExt, rsVal, rtVal, aluB, aluRes, rdData;
  logic         aluZero, imemWe, dmemWe, loadData2Dmem;
  logic [MEM_AW-1:0] dmemWAddr;
  logic [W-1:0]      dmemWData;

  always_ff @(posedge clk) begin
    if (rst) pc <= '0;
    else     pc <= nextPc;
  end

  assign imemWe = loadEn & ~loadToData;

  sc_mem #(.W(W), .AW(MEM_AW)) uImem (
    .clk(clk), .we(imemWe), .wAddr(loadAddr), .wData(loadData),
    .rAddr(pc[MEM_AW+1:2]), .rData(instr)
  );

  sc_regfile #(.W(W), .REG_AW(REG_AW)) uRegs (
    .clk(clk), .we(wbEn), .wAddr(wbReg), .wData(wbData),
    .rAddrA(instr[25:21]), .rAddrB(instr[20:16]),
    .rDataA(rsVal), .rDataB(rtVal)
  );

  assign immExt = ctrl.extSign ? {{(W-IMM_W){instr[15]}}, instr[15:0]}
                               : {{(W-IMM_W){1'b0}}, instr[15:0]};
  assign aluB   = ctrl.aluSrcImm ? immExt : rtVal;

  always_comb begin
    case (ctrl.aluOp)
      ALU_SUB: aluRes = rsVal - aluB;
      ALU_OR:  aluRes = rsVal | aluB;
      default: aluRes = rsVal + aluB;
    endcase
  end
  assign aluZero = (aluRes == '0);

  assign loadData2Dmem = loadEn & loadToData;
  assign dmemWe    = loadData2Dmem | memWe;
  assign dmemWAddr = loadData2Dmem ? loadAddr : aluRes[MEM_AW+1:2];
  assign dmemWData = loadData2Dmem ? loadData : rtVal;

  sc_mem #(.W(W), .AW(MEM_AW)) uDmem (
    .clk(clk), .we(dmemWe), .wAddr(dmemWAddr), .wData(dmemWData),
    .rAddr(aluRes[MEM_AW+1:2]), .rData(rdData)
  );

  assign pcPlus4 = pc + W'(4);
  assign brTgt   = pcPlus4 + (immExt << 2);
  assign jTgt    = {pcPlus4[W-1 -: HIGH_W], instr[TGT_W-1:0], 2'b00};

  always_comb begin
    if (ctrl.jump)                  nextPc = jTgt;
    else if (ctrl.branch && aluZero) nextPc = brTgt;
    else                            nextPc = pcPlus4;
  end

  assign pcOut    = pc;
  assign wbEn     = ctrl.regWrite & ~rst;
  assign wbReg    = ctrl.regDst ? instr[15:11] : instr[20:16];
  assign wbData   = ctrl.memToReg ? rdData : aluRes;
  assign memWe    = ctrl.memWrite & ~rst;
  assign memAddr  = aluRes;
  assign memWdata = rtVal;
endmodule

// File: rtl/sc_core.sv
module sc_core
  import sc_pkg::*;
#(
  parameter int W      = 32,
  parameter int REG_AW = 5,
  parameter int MEM_AW = 6
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              loadEn,
  input  logic              loadToData,
  input  logic [MEM_AW-1:0] loadAddr,
  input  logic [W-1:0]      loadData,
  output logic [W-1:0]      pcOut,
  output logic              wbEn,
  output logic [REG_AW-1:0] wbReg,
  output logic [W-1:0]      wbData,
  output logic              memWe,
  output logic [W-1:0]      memAddr,
  output logic [W-1:0]      memWdata
);
  ctrl_t        ctrl;
  logic [W-1:0] instr;

  sc_control uCtrl (
    .opcode(instr[31:26]), .funct(instr[5:0]), .ctrl(ctrl)
  );

  sc_datapath #(.W(W), .REG_AW(REG_AW), .MEM_AW(MEM_AW)) uPath (
    .clk(clk), .rst(rst), .ctrl(ctrl), .instr(instr),
    .loadEn(loadEn), .loadToData(loadToData), .loadAddr(loadAddr),
    .loadData(loadData), .pcOut(pcOut), .wbEn(wbEn), .wbReg(wbReg),
    .wbData(wbData), .memWe(memWe), .memAddr(memAddr), .memWdata(memWdata)
  );
endmodule

// File: rtl/sc_core_chk.sv
module sc_core_chk
  import sc_pkg::*;
(
  input logic        clk,
  input logic        rst,
  input logic [31:0] pcOut,
  input logic [31:0] instr,
  input logic        wbEn,
  input logic        memWe
);
  logic [5:0]  op;
  logic        isRtKnown, isKnown, rstSeen;
  logic [31:0] seqPc, brPc, jPc;

  assign op        = instr[31:26];
  assign isRtKnown = (op == OP_RTYPE) && (instr[5:0] == FN_ADD || instr[5:0] == FN_SUB);
  assign isKnown   = isRtKnown || op == OP_ORI || op == OP_LW || op == OP_SW ||
                     op == OP_BEQ || op == OP_J;
  assign seqPc     = pcOut + 32'd4;
  assign brPc      = seqPc + {{14{instr[15]}}, instr[15:0], 2'b00};
  assign jPc       = {seqPc[31:28], instr[25:0], 2'b00};

  always_ff @(posedge clk) rstSeen <= rst;

  always_ff @(posedge clk) begin
    if (rstSeen) AST_RESET_PC: assert (pcOut == 32'd0); // R1
  end

  AST_SEQ_PC: assert property (@(posedge clk) disable iff (rst)
    (op != OP_BEQ && op != OP_J) |=> pcOut == $past(seqPc)); // R10

  AST_BEQ_PC: assert property (@(posedge clk) disable iff (rst)
    (op == OP_BEQ) |=> (pcOut == $past(seqPc) || pcOut == $past(brPc))); // R6

  AST_JUMP_PC: assert property (@(posedge clk) disable iff (rst)
    (op == OP_J) |=> pcOut == $past(jPc)); // R7

  AST_STORE_ONLY: assert property (@(posedge clk) disable iff (rst)
    memWe |-> op == OP_SW); // R5

  AST_WB_ONLY: assert property (@(posedge clk) disable iff (rst)
    wbEn |-> (isRtKnown || op == OP_ORI || op == OP_LW)); // R5

  AST_UNKNOWN_NOP: assert property (@(posedge clk) disable iff (rst)
    !isKnown |-> (!wbEn && !memWe)); // R9
endmodule

bind sc_core sc_core_chk uChk (
  .clk(clk), .rst(rst), .pcOut(pcOut), .instr(instr),
  .wbEn(wbEn), .memWe(memWe)
);

// File: tb/sc_core_test.sv
module sc_core_test;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        loadEn = 1'b0;
  logic        loadToData = 1'b0;
  logic [5:0]  loadAddr = '0;
  logic [31:0] loadData = '0;
  logic [31:0] pcOut, wbData, memAddr, memWdata;
  logic        wbEn, memWe;
  logic [4:0]  wbReg;

  int checks = 0;
  int fails  = 0;
  bit done   = 1'b0;

  always #4 clk = ~clk;

  sc_core uut (
    .clk(clk), .rst(rst), .loadEn(loadEn), .loadToData(loadToData),
    .loadAddr(loadAddr), .loadData(loadData), .pcOut(pcOut), .wbEn(wbEn),
    .wbReg(wbReg), .wbData(wbData), .memWe(memWe), .memAddr(memAddr),
    .memWdata(memWdata)
  );

  function automatic logic [31:0] rIns(int rs, int rt, int rd, logic [5:0] fn);
    return {6'b000000, 5'(rs), 5'(rt), 5'(rd), 5'd0, fn};
  endfunction
  function automatic logic [31:0] iIns(logic [5:0] op, int rs, int rt, logic [15:0] imm);
    return {op, 5'(rs), 5'(rt), imm};
  endfunction
  function automatic logic [31:0] jIns(logic [25:0] tgt);
    return {6'b000010, tgt};
  endfunction

  task automatic chk(string tag, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic loadWord(bit toData, int addr, logic [31:0] data);
    @(negedge clk);
    loadEn = 1'b1; loadToData = toData; loadAddr = 6'(addr); loadData = data;
    @(negedge clk);
    loadEn = 1'b0;
  endtask

  // Check the current cycle, then move to the next one.
  task automatic step(string tag, logic [31:0] expPc, bit expWb, int expReg,
                      logic [31:0] expWbData, bit expSt, logic [31:0] expAddr,
                      logic [31:0] expStData);
    chk({tag, " pc"}, pcOut, expPc);
    chk({tag, " wbEn"}, 32'(wbEn), 32'(expWb));
    chk({tag, " memWe"}, 32'(memWe), 32'(expSt));
    if (expWb) begin
      chk({tag, " wbReg"}, 32'(wbReg), 32'(expReg));
      chk({tag, " wbData"}, wbData, expWbData);
    end
    if (expSt) begin
      chk({tag, " memAddr"}, memAddr, expAddr);
      chk({tag, " memWdata"}, memWdata, expStData);
    end
    @(negedge clk); #1;
  endtask

  task automatic loadProgram();
    loadWord(0, 0,  iIns(6'b001101, 0, 1, 16'h8005));
    loadWord(0, 1,  iIns(6'b001101, 0, 2, 16'h0003));
    loadWord(0, 2,  rIns(1, 2, 3, 6'b100000));
    loadWord(0, 3,  rIns(2, 1, 4, 6'b100010));
    loadWord(0, 4,  iIns(6'b101011, 0, 3, 16'h0008));
    loadWord(0, 5,  iIns(6'b100011, 0, 5, 16'h0008));
    loadWord(0, 6,  iIns(6'b001101, 0, 8, 16'h0010));
    loadWord(0, 7,  iIns(6'b101011, 8, 4, 16'hFFFC));
    loadWord(0, 8,  iIns(6'b100011, 8, 9, 16'hFFFC));
    loadWord(0, 9,  iIns(6'b001101, 0, 0, 16'h1234));
    loadWord(0, 10, rIns(0, 0, 10, 6'b100000));
    loadWord(0, 11, iIns(6'b100011, 0, 13, 16'h0014));
    loadWord(0, 12, {6'b111111, 26'h0123456});
    loadWord(0, 13, rIns(1, 2, 11, 6'b100101));
    loadWord(0, 14, iIns(6'b000100, 1, 2, 16'h0005));
    loadWord(0, 15, iIns(6'b000100, 5, 3, 16'h0002));
    loadWord(0, 16, iIns(6'b001101, 0, 14, 16'h0BAD));
    loadWord(0, 17, iIns(6'b001101, 0, 14, 16'h0BAD));
    loadWord(0, 18, jIns(26'd21));
    loadWord(0, 19, iIns(6'b001101, 0, 14, 16'h0BAD));
    loadWord(0, 20, iIns(6'b001101, 0, 14, 16'h0BAD));
    loadWord(0, 21, iIns(6'b000100, 0, 0, 16'hFFFF));
    loadWord(1, 5,  32'hCAFEF00D);
  endtask

  task automatic testReset();
    @(negedge clk); #1;
    chk("R1 pc in reset", pcOut, 32'd0);
    chk("R1 wbEn in reset", 32'(wbEn), 32'd0);
    chk("R1 memWe in reset", 32'(memWe), 32'd0);
    @(negedge clk);
    rst = 1'b0;
    #1;
  endtask

  task automatic testArith();
    step("R11 R3 ori zero-ext", 32'd0,  1, 1, 32'h00008005, 0, 0, 0);
    step("R3 ori small",        32'd4,  1, 2, 32'h00000003, 0, 0, 0);
    step("R2 add",              32'd8,  1, 3, 32'h00008008, 0, 0, 0);
    step("R2 sub",              32'd12, 1, 4, 32'hFFFF7FFE, 0, 0, 0);
  endtask

  task automatic testMemory();
    step("R4 sw store",         32'd16, 0, 0, 0, 1, 32'd8, 32'h00008008);
    step("R4 lw reload",        32'd20, 1, 5, 32'h00008008, 0, 0, 0);
    step("R10 ori base",        32'd24, 1, 8, 32'd16, 0, 0, 0);
    step("R4 sw negative off",  32'd28, 0, 0, 0, 1, 32'd12, 32'hFFFF7FFE);
    step("R4 lw negative off",  32'd32, 1, 9, 32'hFFFF7FFE, 0, 0, 0);
  endtask

  task automatic testZeroReg();
    step("R8 write r0",         32'd36, 1, 0, 32'h00001234, 0, 0, 0);
    step("R8 r0 reads zero",    32'd40, 1, 10, 32'd0, 0, 0, 0);
    step("R11 R4 lw preloaded", 32'd44, 1, 13, 32'hCAFEF00D, 0, 0, 0);
  endtask

  task automatic testNoop();
    step("R9 unknown opcode",   32'd48, 0, 0, 0, 0, 0, 0);
    step("R9 unknown funct",    32'd52, 0, 0, 0, 0, 0, 0);
  endtask

  task automatic testBranch();
    step("R6 beq not taken",    32'd56, 0, 0, 0, 0, 0, 0);
    step("R6 beq taken",        32'd60, 0, 0, 0, 0, 0, 0);
  endtask

  task automatic testJump();
    step("R6 R7 jump at target", 32'd72, 0, 0, 0, 0, 0, 0);
    step("R7 beq self loop",     32'd84, 0, 0, 0, 0, 0, 0);
    step("R6 backward branch",   32'd84, 0, 0, 0, 0, 0, 0);
    chk("R6 loop holds", pcOut, 32'd84);
  endtask

  initial begin
    loadProgram();
    testReset();
    testArith();
    testMemory();
    testZeroReg();
    testNoop();
    testBranch();
    testJump();
    done = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    repeat (5000) @(posedge clk);
    if (!done) begin
      checks++;
      fails++;
      $display("FAIL watchdog actual=running expected=finished");
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end
endmodule